// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block turns one configuration-space request from a host register interface into PCI configuration cycles. A request gives a bus, a device, a function, a register offset, an access size (byte, halfword or dword), a direction and write data. The block checks the request and builds either a bus-0 address or a bridged-bus address. It then runs one or two dword transactions on a simple initiator port and returns read data with a status code.

The initiator port moves whole dwords only. Byte and halfword reads fetch the enclosing dword and pick out the lane. Byte and halfword writes first read the enclosing dword, place the new lane into it, and write the merged dword back. A missing completion is caught by a timeout, so an absent target cannot hang the host.

Top module: `cfg_access_seq`

## Requirements
- R1: A request is rejected with status 1 (invalid) when the device number is above 15, when the size code is 3, when a dword access (size code 2) has a nonzero offset[1:0], or when a halfword access (size code 1) has offset[0] set. A rejected request starts no initiator transaction. `done` pulses on the cycle after acceptance. Read data is 0xFFFFFFFF for a rejected read and 0 for a rejected write.
- R2: On bus 0 the initiator address is a single set bit at position 16+device, ORed with function<<8 and with the offset whose two low bits are cleared.
- R3: On a nonzero bus the initiator address is bus at bits 23:16, device at bits 15:11, function at bits 10:8, the offset with its two low bits cleared, and bit 0 set.
- R4: A read fetches one dword. The result is zero-extended. For size code 0 it is the byte at bit 8*offset[1:0], for size code 1 the halfword at that position, and for size code 2 the whole dword. Status is 0 (ok).
- R5: A completion that reports abort yields status 2. Read data is taken from an all-ones dword. `ini_abort_clr` pulses once, on the cycle after each aborted completion.
- R6: A dword write (size code 2) makes exactly one write transaction carrying the request data, with no read transaction first.
- R7: A halfword write reads the dword and writes it back with the addressed halfword replaced. If that read aborts, the block reports status 2 and issues no write.
- R8: A byte write reads the dword and writes it back with the addressed byte replaced. It writes even when the read aborted, and then merges into all-ones.
- R9: After reset `busy`, `done` and `ini_req` are low. `busy` is high from acceptance until the cycle `done` pulses. Requests offered while busy are ignored. The status and read data hold steady between `done` pulses. Writes return read data 0.
- R10: When no completion comes within TIMEOUT_CYC cycles of an initiator request, that transaction ends as an abort and gives status 2. No `ini_abort_clr` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 dword |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle result pulse |
| rsp_status | output | 2 | 0 ok, 1 invalid, 2 master abort |
| rsp_rdata | output | 32 | Read result |
| ini_req | output | 1 | Initiator transaction request, held until completion |
| ini_write | output | 1 | Initiator direction |
| ini_addr | output | 32 | Initiator configuration address |
| ini_wdata | output | 32 | Initiator write dword |
| ini_abort_clr | output | 1 | Write-one clear of the sticky abort flag |
| ini_ack | input | 1 | Completion pulse |
| ini_abort | input | 1 | Abort flag, valid with ini_ack |
| ini_rdata | input | 32 | Read dword, valid with ini_ack |

## Verification
The hardest cases to reach are in the second phase of a sub-word write. One is a byte write whose read aborts but whose write must still go out with merged all-ones. Another is a timeout that hits in one phase while the other phase still runs. The bench's initiator model chooses an abort flag separately for the read and the write phase, varies its response latency, and can be silenced completely. Random requests spread across both buses, all sizes and lane offsets, and both directions then reach these paths together with the rejection rules.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int unsigned BUS_W  = 8;
    localparam int unsigned DEV_W  = 5;
    localparam int unsigned FN_W   = 3;
    localparam int unsigned OFF_W  = 8;
    localparam int unsigned DW_W   = 32;
    localparam int unsigned LANES  = DW_W / 8;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_INVAL  = 2'd1,
        ST_MABORT = 2'd2
    } rsp_status_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_WR   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  func;
        logic [OFF_W-1:0] off;
        logic [1:0]       size;
        logic             write;
        logic [DW_W-1:0]  wdata;
    } cfg_req_t;

    function automatic logic [LANES-1:0] lane_mask(logic [1:0] size, logic [1:0] lane);
        logic [LANES-1:0] m;
        case (size)
            SZ_BYTE: m = LANES'(1) << lane;
            SZ_HALF: m = LANES'(3) << lane;
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfg_req_check.sv
module cfg_req_check
    import cfg_seq_pkg::*;
#(
    parameter int unsigned MAX_DEV = 15
) (
    input  cfg_req_t        req,
    output logic            ok,
    output logic [DW_W-1:0] addr
);
    logic [OFF_W-1:0] dw_off;
    logic             dev_ok;
    logic             size_ok;
    logic             align_ok;

    assign dw_off = {req.off[OFF_W-1:2], 2'b00};

    always_comb begin
        dev_ok   = (32'(req.dev) <= MAX_DEV);
        size_ok  = (req.size != 2'd3);
        align_ok = 1'b1;
        if (req.size == SZ_WORD && req.off[1:0] != 2'b00) align_ok = 1'b0;
        if (req.size == SZ_HALF && req.off[0])             align_ok = 1'b0;
        ok = dev_ok && size_ok && align_ok;
    end

    always_comb begin
        if (req.bus == '0) begin
            addr = (DW_W'(1) << (16 + 32'(req.dev)))
                 | (DW_W'(req.func) << 8)
                 | DW_W'(dw_off);
        end else begin
            addr = (DW_W'(req.bus) << 16)
                 | (DW_W'(req.dev) << 11)
                 | (DW_W'(req.func) << 8)
                 | DW_W'(dw_off)
                 | DW_W'(1);
        end
    end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
    import cfg_seq_pkg::*;
(
    input  logic [DW_W-1:0] dword,
    input  logic [DW_W-1:0] wdata,
    input  logic [1:0]      size,
    input  logic [1:0]      lane,
    output logic [DW_W-1:0] extracted,
    output logic [DW_W-1:0] merged
);
    logic [LANES-1:0] be;
    logic [DW_W-1:0]  shifted_in;
    logic [DW_W-1:0]  shifted_out;

    assign be          = lane_mask(size, lane);
    assign shifted_in  = wdata << (8 * 32'(lane));
    assign shifted_out = dword >> (8 * 32'(lane));

    always_comb begin
        case (size)
            SZ_BYTE: extracted = {{(DW_W-8){1'b0}},  shifted_out[7:0]};
            SZ_HALF: extracted = {{(DW_W-16){1'b0}}, shifted_out[15:0]};
            default: extracted = dword;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = be[g] ? shifted_in[8*g +: 8] : dword[8*g +: 8];
    end
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int unsigned TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ack,
    output logic expire
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    logic [CW-1:0] cnt;

    assign expire = run && !ack && (cnt == CW'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || ack || expire) cnt <= '0;
        else                              cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
    import cfg_seq_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 64,
    parameter int unsigned MAX_DEV     = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_dev,
    input  logic [2:0]  req_func,
    input  logic [7:0]  req_off,
    input  logic [1:0]  req_size,
    input  logic        req_write,
    input  logic [31:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [1:0]  rsp_status,
    output logic [31:0] rsp_rdata,
    output logic        ini_req,
    output logic        ini_write,
    output logic [31:0] ini_addr,
    output logic [31:0] ini_wdata,
    output logic        ini_abort_clr,
    input  logic        ini_ack,
    input  logic        ini_abort,
    input  logic [31:0] ini_rdata
);
    seq_state_e      state;
    cfg_req_t        req_in;
    cfg_req_t        cur;
    rsp_status_e     status_q;
    logic            chk_ok;
    logic [DW_W-1:0] chk_addr;
    logic [DW_W-1:0] addr_q;
    logic [DW_W-1:0] wbuf;
    logic [DW_W-1:0] dword_in;
    logic [DW_W-1:0] lane_ext;
    logic [DW_W-1:0] lane_mrg;
    logic            expire;
    logic            fin;
    logic            failed;

    assign req_in = '{bus: req_bus, dev: req_dev, func: req_func, off: req_off,
                      size: req_size, write: req_write, wdata: req_wdata};

    cfg_req_check #(.MAX_DEV(MAX_DEV)) u_check (
        .req  (req_in),
        .ok   (chk_ok),
        .addr (chk_addr)
    );

    cfg_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (ini_req),
        .ack    (ini_ack),
        .expire (expire)
    );

    assign fin      = ini_req && (ini_ack || expire);
    assign failed   = !ini_ack || ini_abort;
    assign dword_in = failed ? '1 : ini_rdata;

    cfg_lane_unit u_lane (
        .dword     (dword_in),
        .wdata     (cur.wdata),
        .size      (cur.size),
        .lane      (cur.off[1:0]),
        .extracted (lane_ext),
        .merged    (lane_mrg)
    );

    assign busy       = (state != S_IDLE);
    assign ini_req    = (state == S_RD) || (state == S_WR);
    assign ini_write  = (state == S_WR);
    assign ini_addr   = addr_q;
    assign ini_wdata  = wbuf;
    assign rsp_status = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= S_IDLE;
            cur           <= '0;
            addr_q        <= '0;
            wbuf          <= '0;
            done          <= 1'b0;
            status_q      <= ST_OK;
            rsp_rdata     <= '0;
            ini_abort_clr <= 1'b0;
        end else begin
            done          <= 1'b0;
            ini_abort_clr <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cur    <= req_in;
                        addr_q <= chk_addr;
                        if (!chk_ok) begin
                            done      <= 1'b1;
                            status_q  <= ST_INVAL;
                            rsp_rdata <= req_write ? '0 : '1;
                        end else if (req_write && req_size == SZ_WORD) begin
                            wbuf  <= req_wdata;
                            state <= S_WR;
                        end else begin
                            state <= S_RD;
                        end
                    end
                end
                S_RD: begin
                    if (fin) begin
                        if (ini_ack && ini_abort) ini_abort_clr <= 1'b1;
                        if (!cur.write) begin
                            state     <= S_IDLE;
                            done      <= 1'b1;
                            status_q  <= failed ? ST_MABORT : ST_OK;
                            rsp_rdata <= lane_ext;
                        end else if (cur.size == SZ_HALF && failed) begin
                            state     <= S_IDLE;
                            done      <= 1'b1;
                            status_q  <= ST_MABORT;
                            rsp_rdata <= '0;
                        end else begin
                            wbuf  <= lane_mrg;
                            state <= S_WR;
                        end
                    end
                end
                S_WR: begin
                    if (fin) begin
                        if (ini_ack && ini_abort) ini_abort_clr <= 1'b1;
                        state     <= S_IDLE;
                        done      <= 1'b1;
                        status_q  <= failed ? ST_MABORT : ST_OK;
                        rsp_rdata <= '0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_access_seq_chk.sv
module cfg_access_seq_chk #(
    parameter int unsigned TIMEOUT_CYC = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [1:0]  rsp_status,
    input logic [31:0] rsp_rdata,
    input logic        ini_req,
    input logic        ini_write,
    input logic [31:0] ini_addr,
    input logic        ini_abort_clr,
    input logic        ini_ack,
    input logic        ini_abort
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 2);
    logic [CW-1:0] wait_cnt;
    logic [CW-1:0] eff_cnt;
    logic          wr_q;

    assign eff_cnt = (ini_write != wr_q) ? '0 : wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
            wr_q     <= 1'b0;
        end else begin
            wr_q     <= ini_write;
            wait_cnt <= (ini_req && !ini_ack) ? eff_cnt + CW'(1) : '0;
        end
    end

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r9_req_needs_busy: assert property (@(posedge clk) disable iff (rst)
        ini_req |-> busy);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(rsp_status) && $stable(rsp_rdata)));

    a_r5_clear_follows_abort: assert property (@(posedge clk) disable iff (rst)
        ini_abort_clr |-> $past(ini_ack && ini_abort));

    a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
        (ini_req && $past(ini_req) && !$past(ini_ack)) |-> $stable(ini_addr));

    a_r1_reject_no_bus: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_status == 2'd1) |-> !$past(ini_req));

    a_r10_wait_bounded: assert property (@(posedge clk) disable iff (rst)
        ini_req |-> (32'(eff_cnt) < TIMEOUT_CYC));
endmodule

bind cfg_access_seq cfg_access_seq_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .rsp_status    (rsp_status),
    .rsp_rdata     (rsp_rdata),
    .ini_req       (ini_req),
    .ini_write     (ini_write),
    .ini_addr      (ini_addr),
    .ini_abort_clr (ini_abort_clr),
    .ini_ack       (ini_ack),
    .ini_abort     (ini_abort)
);

// File: tb/cfg_access_seq_tb.sv
`timescale 1ns/1ps
module cfg_access_seq_tb;
    localparam int TO = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_off = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, ini_req, ini_write, ini_abort_clr;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata, ini_addr, ini_wdata;
    logic        ini_ack = 1'b0;
    logic        ini_abort = 1'b0;
    logic [31:0] ini_rdata = '0;

    int tests = 0;
    int fails = 0;

    int          lat = 1;
    int          cnt = 0;
    bit          ab_rd = 0, ab_wr = 0, mute = 0;
    int          n_rd = 0, n_wr = 0, n_clr = 0;
    logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;

    always #4 clk = ~clk;

    cfg_access_seq #(.TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bus(req_bus),
        .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .ini_req(ini_req), .ini_write(ini_write), .ini_addr(ini_addr),
        .ini_wdata(ini_wdata), .ini_abort_clr(ini_abort_clr),
        .ini_ack(ini_ack), .ini_abort(ini_abort), .ini_rdata(ini_rdata)
    );

    function automatic logic [31:0] rdval(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A3C0F69;
    endfunction

    function automatic logic [31:0] b_ext(logic [31:0] d, logic [1:0] sz, logic [1:0] ln);
        logic [31:0] s = d >> (8 * int'(ln));
        if (sz == 2'd0) return s & 32'hFF;
        if (sz == 2'd1) return s & 32'hFFFF;
        return d;
    endfunction

    function automatic logic [31:0] b_merge(logic [31:0] d, logic [31:0] w, logic [1:0] sz, logic [1:0] ln);
        logic [31:0] m = (sz == 2'd0) ? 32'hFF : 32'hFFFF;
        m = m << (8 * int'(ln));
        return (d & ~m) | (((sz == 2'd0) ? (w & 32'hFF) : (w & 32'hFFFF)) << (8 * int'(ln)));
    endfunction

    // initiator model: responds on negedges
    always @(negedge clk) begin
        if (ini_abort_clr) n_clr = n_clr + 1;
        if (ini_ack) begin
            ini_ack = 1'b0; ini_abort = 1'b0; cnt = 0;
        end else if (ini_req && !mute) begin
            if (cnt >= lat) begin
                ini_ack = 1'b1;
                if (ini_write) begin
                    ini_abort = ab_wr; n_wr = n_wr + 1; wr_addr = ini_addr; wr_data = ini_wdata;
                end else begin
                    ini_abort = ab_rd; n_rd = n_rd + 1; rd_addr = ini_addr;
                    ini_rdata = rdval(ini_addr);
                end
            end else cnt = cnt + 1;
        end else cnt = 0;
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(logic [7:0] bus, logic [4:0] dev, logic [2:0] fn, logic [7:0] off,
                       logic [1:0] sz, bit wr, logic [31:0] wd, bit hold, string tag);
        bit          ok;
        logic [31:0] ea, dw, e_rd, e_wd;
        int          e_st, e_nrd, e_nwr, e_clr, k;
        ok = (dev <= 15) && (sz != 2'd3) && !(sz == 2'd2 && off[1:0] != 0) && !(sz == 2'd1 && off[0]);
        if (bus == 0) ea = (32'h1 << (16 + int'(dev))) | (32'(fn) << 8) | 32'(off & 8'hFC);
        else ea = (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | 32'(off & 8'hFC) | 32'h1;
        e_nrd = 0; e_nwr = 0; e_wd = '0; e_rd = '0; e_st = 0;
        dw = (ab_rd || mute) ? 32'hFFFFFFFF : rdval(ea);
        if (!ok) begin
            e_st = 1; e_rd = wr ? 32'h0 : 32'hFFFFFFFF;
        end else if (!wr) begin
            e_nrd = 1; e_st = (ab_rd || mute) ? 2 : 0; e_rd = b_ext(dw, sz, off[1:0]);
        end else if (sz == 2'd2) begin
            e_nwr = 1; e_wd = wd; e_st = (ab_wr || mute) ? 2 : 0;
        end else if (sz == 2'd1 && (ab_rd || mute)) begin
            e_nrd = 1; e_st = 2;
        end else begin
            e_nrd = 1; e_nwr = 1; e_wd = b_merge(dw, wd, sz, off[1:0]);
            e_st = (ab_wr || mute) ? 2 : 0;
        end
        if (mute) begin e_nrd = 0; e_nwr = 0; end
        e_clr = ((e_nrd != 0 && ab_rd) ? 1 : 0) + ((e_nwr != 0 && ab_wr) ? 1 : 0);
        n_rd = 0; n_wr = 0; n_clr = 0;
        @(negedge clk);
        req_bus = bus; req_dev = dev; req_func = fn; req_off = off;
        req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        if (hold) begin req_dev = 5'd31; req_wdata = ~wd; end
        else req_valid = 1'b0;
        if (ok) chk({tag, " R9 busy after accept"}, 32'(busy), 32'd1);
        else    chk({tag, " R1 done next cycle"}, 32'(done), 32'd1);
        k = 0;
        while (!done && k < 3 * TO + 20) begin @(negedge clk); k++; end
        req_valid = 1'b0;
        chk({tag, " status"}, 32'(rsp_status), 32'(e_st));
        chk({tag, " rdata"}, rsp_rdata, e_rd);
        chk({tag, " R9 not busy at done"}, 32'(busy), 32'd0);
        @(negedge clk);
        chk({tag, " read txn count"}, 32'(n_rd), 32'(e_nrd));
        chk({tag, " write txn count"}, 32'(n_wr), 32'(e_nwr));
        chk({tag, " R5 abort clear pulses"}, 32'(n_clr), 32'(e_clr));
        if (e_nrd != 0) chk({tag, " R2/R3 read addr"}, rd_addr, ea);
        if (e_nwr != 0) begin
            chk({tag, " R2/R3 write addr"}, wr_addr, ea);
            chk({tag, " write data"}, wr_data, e_wd);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [1:0]  hs;
        logic [31:0] hr;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset busy", 32'(busy), 0);
        chk("R9 reset done", 32'(done), 0);
        chk("R9 reset ini_req", 32'(ini_req), 0);
        chk("R9 reset status", 32'(rsp_status), 0);

        run(8'h00, 5'd3,  3'd2, 8'h10, 2'd2, 0, 0, 0, "R2 type0 read");
        run(8'h00, 5'd15, 3'd7, 8'hFC, 2'd2, 0, 0, 0, "R2 top idsel");
        run(8'h5A, 5'd9,  3'd7, 8'h3C, 2'd2, 0, 0, 0, "R3 type1 read");
        run(8'h00, 5'd16, 3'd0, 8'h00, 2'd2, 0, 0, 0, "R1 dev16 read");
        run(8'h00, 5'd1,  3'd0, 8'h05, 2'd1, 0, 0, 0, "R1 odd half");
        run(8'h00, 5'd1,  3'd0, 8'h02, 2'd2, 0, 0, 0, "R1 misaligned word");
        run(8'h03, 5'd1,  3'd0, 8'h00, 2'd3, 0, 0, 0, "R1 size3");
        run(8'h00, 5'd20, 3'd0, 8'h00, 2'd2, 1, 32'h1234, 0, "R1 rejected write");
        run(8'h00, 5'd4,  3'd1, 8'h13, 2'd0, 0, 0, 0, "R4 byte read");
        run(8'h07, 5'd4,  3'd1, 8'h0E, 2'd1, 0, 0, 0, "R4 half read hi");
        run(8'h00, 5'd4,  3'd1, 8'h00, 2'd1, 0, 0, 0, "R4 half read lo");
        ab_rd = 1;
        run(8'h00, 5'd6,  3'd0, 8'h21, 2'd0, 0, 0, 0, "R5 abort byte read");
        run(8'h02, 5'd6,  3'd0, 8'h20, 2'd2, 0, 0, 0, "R5 abort word read");
        run(8'h00, 5'd2,  3'd0, 8'h06, 2'd1, 1, 32'hBEEF, 0, "R7 half write read abort");
        run(8'h00, 5'd2,  3'd3, 8'h21, 2'd0, 1, 32'h77, 0, "R8 byte write read abort");
        ab_rd = 0;
        run(8'h00, 5'd5,  3'd0, 8'h40, 2'd2, 1, 32'hCAFEF00D, 0, "R6 word write");
        ab_wr = 1;
        run(8'h11, 5'd5,  3'd0, 8'h40, 2'd2, 1, 32'h0BADBEEF, 0, "R5 R6 word write abort");
        ab_wr = 0;
        run(8'h00, 5'd2,  3'd0, 8'h06, 2'd1, 1, 32'hBEEF, 0, "R7 half write");
        run(8'h00, 5'd2,  3'd0, 8'h03, 2'd0, 1, 32'hA5, 0, "R8 byte write");
        mute = 1;
        run(8'h00, 5'd8,  3'd0, 8'h08, 2'd2, 0, 0, 0, "R10 timeout read");
        run(8'h09, 5'd8,  3'd0, 8'h09, 2'd0, 1, 32'h3C, 0, "R10 timeout byte write");
        mute = 0;
        lat = 3;
        run(8'h00, 5'd7,  3'd5, 8'h30, 2'd2, 0, 0, 1, "R9 ignore while busy");
        hs = rsp_status; hr = rsp_rdata;
        repeat (3) @(negedge clk);
        chk("R9 result hold status", 32'(rsp_status), 32'(hs));
        chk("R9 result hold rdata", rsp_rdata, hr);

        for (int i = 0; i < 300; i++) begin
            logic [7:0] b;
            b = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
            lat = int'($urandom % 4);
            ab_rd = ($urandom % 8 == 0);
            ab_wr = ($urandom % 8 == 0);
            run(b, 5'($urandom % 20), 3'($urandom), 8'($urandom), 2'($urandom),
                1'($urandom), $urandom, 0, "R1-R9 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule